// File: doc/BRIEF.md
# Exception Priority and Trace Sequencer

This block sits beside a small CPU core and decides which exception the core services next. It watches three abort strobes (reset request, address error, bus error), an interrupt request with its level, and the start and end of every instruction. At the end of each instruction the core reports a status code and, for a trap instruction, a 4-bit trap number. The trace enable bit is sampled when an instruction starts.

Pending events are ranked in one fixed order: reset, address error, bus error, the fault raised by the finished instruction, trace, and then interrupt. The block shows one vector number at a time with a valid flag. It holds that vector until the core's stacking logic returns a one-cycle accept. An event recorded at a clock edge can be shown from the following edge. After an accept, the next queued vector appears one cycle later.

A single instruction can therefore produce a sequence of vectors. A trap taken with tracing enabled and an interrupt waiting gives the trap vector first, then the trace vector, then the interrupt vector.

Top module: `exc_sequencer`

## Requirements
- R1: Abort events are ranked reset (vector 0) above address error (vector 3) above bus error (vector 2). Strobes that arrive together are shown in that order.
- R2: An abort strobe during an instruction cancels it. That instruction produces no trace vector, and an end strobe in the same cycle is ignored.
- R3: A reset request drops any fault and trace waiting to be shown. A vector already on the output stays until it is accepted, and vector 0 follows.
- R4: Status codes at the end of an instruction are: 0 normal, 1 illegal, 2 privileged in user state, 3 opcode line 1010, 4 opcode line 1111, 5 trap, 6 overflow trap, 7 bounds check, 8 divide by zero, 9 format error. Codes 10 to 15 count as normal. Codes 1 to 9 give vectors 4, 8, 10, 11, 32 plus the trap number, 7, 6, 5 and 14 respectively.
- R5: The trace bit is sampled at instruction start. When it was set and the instruction ran to its end, the block raises trace vector 9. Running to the end means code 0, codes 5 to 9, or codes 10 to 15.
- R6: An instruction ending with code 1, 2, 3 or 4 gives its own vector and never a trace vector, whatever the trace bit was.
- R7: After one instruction, the fault vector comes before trace, and trace comes before interrupt.
- R8: The interrupt vector is 24 plus the level. It is shown only when nothing else is waiting, no instruction is in progress or starting, and the output stage was empty on the previous cycle.
- R9: A shown vector stays valid and unchanged until accepted. When anything other than an interrupt is still waiting, the next vector is valid in the cycle after the accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| reset_req | input | 1 | Reset request strobe from the system |
| addr_err | input | 1 | Address error abort strobe |
| bus_err | input | 1 | Bus error abort strobe |
| irq_pend | input | 1 | Interrupt waiting (level signal) |
| irq_level | input | LVL_W | Level of the waiting interrupt |
| instr_start | input | 1 | Strobe: an instruction begins |
| trace_bit | input | 1 | Trace enable, sampled with instr_start |
| instr_done | input | 1 | Strobe: the instruction has ended |
| instr_status | input | 4 | End status code (see R4) |
| trap_num | input | TRAP_W | Trap number carried with code 5 |
| vec_accept | input | 1 | One-cycle accept of the shown vector |
| vec_valid | output | 1 | A vector is shown |
| vec_num | output | 8 | Shown vector number |

## Verification
The assertions assume the following about the core:
- Every strobe lasts one cycle.
- instr_start and instr_done never coincide.
- No instruction starts while a vector is shown or a fault or trace is waiting.
- irq_pend falls in the cycle the interrupt vector is accepted.

The stimulus follows these rules by construction. Each instruction is run only after the previous sequence of vectors has drained. Interrupts are raised either alongside an end strobe or while an instruction is in progress, and are lowered together with their accept. A behavioural queue model in the bench is compared with the outputs on every cycle.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int VEC_W = 8;

  localparam logic [3:0] ST_NORMAL  = 4'd0;
  localparam logic [3:0] ST_ILLEGAL = 4'd1;
  localparam logic [3:0] ST_PRIV    = 4'd2;
  localparam logic [3:0] ST_LINE_A  = 4'd3;
  localparam logic [3:0] ST_LINE_F  = 4'd4;
  localparam logic [3:0] ST_TRAP    = 4'd5;
  localparam logic [3:0] ST_TRAPV   = 4'd6;
  localparam logic [3:0] ST_CHK     = 4'd7;
  localparam logic [3:0] ST_DIVZ    = 4'd8;
  localparam logic [3:0] ST_FORMAT  = 4'd9;

  localparam logic [VEC_W-1:0] VEC_RESET = 8'd0;
  localparam logic [VEC_W-1:0] VEC_BUS   = 8'd2;
  localparam logic [VEC_W-1:0] VEC_ADDR  = 8'd3;
  localparam logic [VEC_W-1:0] VEC_TRACE = 8'd9;

  // index of each source in the arbiter request vector, highest rank first
  typedef enum int {
    SRC_RESET = 0,
    SRC_ADDR  = 1,
    SRC_BUS   = 2,
    SRC_FAULT = 3,
    SRC_TRACE = 4,
    SRC_IRQ   = 5
  } src_e;
  localparam int NSRC = 6;

  // the instruction was carried out to its end (trace may follow)
  function automatic logic ran_to_end(input logic [3:0] st);
    return !(st == ST_ILLEGAL || st == ST_PRIV ||
             st == ST_LINE_A  || st == ST_LINE_F);
  endfunction

  // the end status carries an exception of its own
  function automatic logic raises_fault(input logic [3:0] st);
    return (st >= ST_ILLEGAL) && (st <= ST_FORMAT);
  endfunction

  function automatic logic [VEC_W-1:0] fault_vector(input logic [3:0] st,
                                                    input logic [VEC_W-1:0] tnum);
    logic [VEC_W-1:0] v;
    case (st)
      ST_ILLEGAL: v = 8'd4;
      ST_PRIV:    v = 8'd8;
      ST_LINE_A:  v = 8'd10;
      ST_LINE_F:  v = 8'd11;
      ST_TRAP:    v = 8'd32 + tnum;
      ST_TRAPV:   v = 8'd7;
      ST_CHK:     v = 8'd6;
      ST_DIVZ:    v = 8'd5;
      ST_FORMAT:  v = 8'd14;
      default:    v = 8'd0;
    endcase
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] irq_vector(input logic [VEC_W-1:0] lvl);
    return 8'd24 + lvl;
  endfunction
endpackage

// File: rtl/exc_abort_flags.sv
module exc_abort_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= 1'b0;
      else if (set_i[i])  pend_q <= 1'b1;   // a new strobe wins over a take
      else if (take_i[i]) pend_q <= 1'b0;
    end
    assign pend_o[i] = pend_q;
  end
endmodule

// File: rtl/exc_instr_tracker.sv
module exc_instr_tracker
  import exc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_start,
  input  logic             trace_bit,
  input  logic             instr_done,
  input  logic [3:0]       instr_status,
  input  logic [VEC_W-1:0] trap_num_ext,
  input  logic             abort_any,
  input  logic             reset_req,
  input  logic             take_fault,
  input  logic             take_trace,
  output logic             in_instr,
  output logic             trace_armed,
  output logic             fault_pend,
  output logic [VEC_W-1:0] fault_vec,
  output logic             trace_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_instr    <= 1'b0;
      trace_armed <= 1'b0;
      fault_pend  <= 1'b0;
      fault_vec   <= '0;
      trace_pend  <= 1'b0;
    end else begin
      if (take_fault) fault_pend <= 1'b0;
      if (take_trace) trace_pend <= 1'b0;
      if (reset_req) begin
        fault_pend <= 1'b0;
        trace_pend <= 1'b0;
      end
      if (abort_any) begin
        in_instr    <= 1'b0;
        trace_armed <= 1'b0;
      end else if (instr_done) begin
        in_instr    <= 1'b0;
        trace_armed <= 1'b0;
        if (raises_fault(instr_status)) begin
          fault_pend <= 1'b1;
          fault_vec  <= fault_vector(instr_status, trap_num_ext);
        end
        if (trace_armed && ran_to_end(instr_status)) trace_pend <= 1'b1;
      end else if (instr_start) begin
        in_instr    <= 1'b1;
        trace_armed <= trace_bit;
      end
    end
  end
endmodule

// File: rtl/exc_vec_arbiter.sv
module exc_vec_arbiter
  import exc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       g0_pend,     // [0] reset, [1] address, [2] bus
  input  logic             fault_pend,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic             trace_pend,
  input  logic             irq_ok,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             vec_accept,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_num,
  output logic [NSRC-1:0]  take
);
  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  sel;
  logic [VEC_W-1:0] cand [NSRC];
  logic [VEC_W-1:0] pick;
  logic             found;
  logic             load;

  assign req[SRC_RESET] = g0_pend[0];
  assign req[SRC_ADDR]  = g0_pend[1];
  assign req[SRC_BUS]   = g0_pend[2];
  assign req[SRC_FAULT] = fault_pend;
  assign req[SRC_TRACE] = trace_pend;
  assign req[SRC_IRQ]   = irq_ok && !vec_valid;

  assign cand[SRC_RESET] = VEC_RESET;
  assign cand[SRC_ADDR]  = VEC_ADDR;
  assign cand[SRC_BUS]   = VEC_BUS;
  assign cand[SRC_FAULT] = fault_vec;
  assign cand[SRC_TRACE] = VEC_TRACE;
  assign cand[SRC_IRQ]   = irq_vec;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NSRC; i++) pick = pick | (sel[i] ? cand[i] : '0);
  end

  assign load = !vec_valid || vec_accept;
  assign take = load ? sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_num   <= '0;
    end else if (load) begin
      vec_valid <= found;
      if (found) vec_num <= pick;
    end
  end
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_seq_pkg::*;
#(
  parameter int TRAP_W = 4,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic              addr_err,
  input  logic              bus_err,
  input  logic              irq_pend,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              instr_start,
  input  logic              trace_bit,
  input  logic              instr_done,
  input  logic [3:0]        instr_status,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic              vec_accept,
  output logic              vec_valid,
  output logic [7:0]        vec_num
);
  localparam int TPAD = VEC_W - TRAP_W;
  localparam int LPAD = VEC_W - LVL_W;

  // named internal events, also observed by the checker
  logic [2:0]       g0_pend;
  logic [2:0]       take_g0;
  logic             abort_any;
  logic             in_instr;
  logic             trace_armed;
  logic             fault_pend;
  logic [VEC_W-1:0] fault_vec;
  logic             trace_pend;
  logic             irq_ok;
  logic [NSRC-1:0]  take;
  logic             take_fault;
  logic             take_trace;
  logic             take_irq;
  logic [VEC_W-1:0] trap_num_ext;
  logic [VEC_W-1:0] irq_vec;

  assign abort_any    = reset_req || addr_err || bus_err;
  assign trap_num_ext = {{TPAD{1'b0}}, trap_num};
  assign irq_vec      = irq_vector({{LPAD{1'b0}}, irq_level});
  assign irq_ok       = irq_pend && !in_instr && !instr_start;

  assign take_g0    = take[SRC_BUS:SRC_RESET];
  assign take_fault = take[SRC_FAULT];
  assign take_trace = take[SRC_TRACE];
  assign take_irq   = take[SRC_IRQ];

  exc_abort_flags #(.N(3)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ({bus_err, addr_err, reset_req}),
    .take_i (take_g0),
    .pend_o (g0_pend)
  );

  exc_instr_tracker u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_start  (instr_start),
    .trace_bit    (trace_bit),
    .instr_done   (instr_done),
    .instr_status (instr_status),
    .trap_num_ext (trap_num_ext),
    .abort_any    (abort_any),
    .reset_req    (reset_req),
    .take_fault   (take_fault),
    .take_trace   (take_trace),
    .in_instr     (in_instr),
    .trace_armed  (trace_armed),
    .fault_pend   (fault_pend),
    .fault_vec    (fault_vec),
    .trace_pend   (trace_pend)
  );

  exc_vec_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .g0_pend    (g0_pend),
    .fault_pend (fault_pend),
    .fault_vec  (fault_vec),
    .trace_pend (trace_pend),
    .irq_ok     (irq_ok),
    .irq_vec    (irq_vec),
    .vec_accept (vec_accept),
    .vec_valid  (vec_valid),
    .vec_num    (vec_num),
    .take       (take)
  );
endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reset_req,
  input logic       instr_done,
  input logic [3:0] instr_status,
  input logic       vec_accept,
  input logic       vec_valid,
  input logic [7:0] vec_num,
  input logic [2:0] g0_pend,
  input logic [2:0] take_g0,
  input logic       abort_any,
  input logic       in_instr,
  input logic       trace_armed,
  input logic       fault_pend,
  input logic       trace_pend,
  input logic       take_fault,
  input logic       take_trace,
  input logic       take_irq
);
  AST_ADDR_BELOW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    take_g0[1] |-> !g0_pend[0]); // R1
  AST_BUS_BELOW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    take_g0[2] |-> !g0_pend[0] && !g0_pend[1]); // R1
  AST_TRACE_ONLY_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_pend) |-> $past(instr_done) && $past(trace_armed) && !$past(abort_any)); // R2
  AST_RESET_DROPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !fault_pend && !trace_pend); // R3
  AST_SKIPPED_GIVES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done && !abort_any && instr_status >= 4'd1 && instr_status <= 4'd4
    |=> fault_pend); // R6
  AST_TRACE_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    take_trace |-> !fault_pend && g0_pend == 3'b000); // R7
  AST_IRQ_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !fault_pend && !trace_pend && !in_instr && !vec_valid); // R8
  AST_HOLD_UNTIL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_accept |=> vec_valid && $stable(vec_num)); // R9
  AST_NEXT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_accept && (g0_pend != 3'b000 || fault_pend || trace_pend)
    |=> vec_valid); // R9
  AST_FAULT_TAKE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |-> fault_pend && g0_pend == 3'b000); // R7
endmodule

bind exc_sequencer exc_sequencer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reset_req    (reset_req),
  .instr_done   (instr_done),
  .instr_status (instr_status),
  .vec_accept   (vec_accept),
  .vec_valid    (vec_valid),
  .vec_num      (vec_num),
  .g0_pend      (g0_pend),
  .take_g0      (take_g0),
  .abort_any    (abort_any),
  .in_instr     (in_instr),
  .trace_armed  (trace_armed),
  .fault_pend   (fault_pend),
  .trace_pend   (trace_pend),
  .take_fault   (take_fault),
  .take_trace   (take_trace),
  .take_irq     (take_irq)
);

// File: tb/exc_sequencer_tb.sv
module exc_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reset_req = 0, addr_err = 0, bus_err = 0, irq_pend = 0;
  logic [2:0] irq_level = 0;
  logic       instr_start = 0, trace_bit = 0, instr_done = 0;
  logic [3:0] instr_status = 0;
  logic [3:0] trap_num = 0;
  logic       vec_accept = 0;
  logic       vec_valid;
  logic [7:0] vec_num;

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R9";

  always #4 clk = ~clk;

  exc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .addr_err(addr_err),
    .bus_err(bus_err), .irq_pend(irq_pend), .irq_level(irq_level),
    .instr_start(instr_start), .trace_bit(trace_bit), .instr_done(instr_done),
    .instr_status(instr_status), .trap_num(trap_num), .vec_accept(vec_accept),
    .vec_valid(vec_valid), .vec_num(vec_num)
  );

  // ---------------- behavioural reference model ----------------
  bit m_rst, m_addr, m_bus, m_busy, m_arm, m_valid;
  int m_vec;
  int m_q[$];

  function automatic int expected_fault(int st, int tn);
    case (st)
      1: return 4;   2: return 8;   3: return 10;  4: return 11;
      5: return 32 + tn;
      6: return 7;   7: return 6;   8: return 5;   9: return 14;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst = 0; m_addr = 0; m_bus = 0; m_busy = 0; m_arm = 0;
      m_valid = 0; m_vec = 0; m_q.delete();
    end else begin
      bit nvalid; int nvec; bit t_rst, t_addr, t_bus, t_q;
      nvalid = m_valid; nvec = m_vec;
      t_rst = 0; t_addr = 0; t_bus = 0; t_q = 0;
      if (!m_valid || vec_accept) begin
        nvalid = 1;
        if (m_rst)            begin nvec = 0; t_rst = 1; end
        else if (m_addr)      begin nvec = 3; t_addr = 1; end
        else if (m_bus)       begin nvec = 2; t_bus = 1; end
        else if (m_q.size())  begin nvec = m_q[0]; t_q = 1; end
        else if (!m_valid && irq_pend && !m_busy && !instr_start)
          nvec = 24 + int'(irq_level);
        else nvalid = 0;
      end
      m_rst  = reset_req | (m_rst  & !t_rst);
      m_addr = addr_err  | (m_addr & !t_addr);
      m_bus  = bus_err   | (m_bus  & !t_bus);
      if (t_q) void'(m_q.pop_front());
      if (reset_req) m_q.delete();
      if (reset_req || addr_err || bus_err) begin
        m_busy = 0; m_arm = 0;
      end else if (instr_done) begin
        int f;
        f = expected_fault(int'(instr_status), int'(trap_num));
        if (f >= 0) m_q.push_back(f);
        if (m_arm && !(instr_status >= 1 && instr_status <= 4)) m_q.push_back(9);
        m_busy = 0; m_arm = 0;
      end else if (instr_start) begin
        m_busy = 1; m_arm = trace_bit;
      end
      m_valid = nvalid; m_vec = nvec;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (vec_valid !== m_valid || (m_valid && vec_num !== 8'(m_vec))) begin
        fails++;
        $display("FAIL %s cycle compare: valid=%0b vec=%0d expected valid=%0b vec=%0d",
                 tag, vec_valid, vec_num, m_valid, m_vec);
      end
    end
  end

  // ---------------- stimulus tasks (called at a falling edge) ----------------
  task automatic pulse_abort(bit r, bit a, bit b);
    reset_req = r; addr_err = a; bus_err = b;
    @(negedge clk);
    reset_req = 0; addr_err = 0; bus_err = 0;
  endtask

  task automatic begin_instr(bit tr);
    instr_start = 1; trace_bit = tr;
    @(negedge clk);
    instr_start = 0; trace_bit = 0;
  endtask

  task automatic end_instr(logic [3:0] st, logic [3:0] tn);
    instr_done = 1; instr_status = st; trap_num = tn;
    @(negedge clk);
    instr_done = 0; instr_status = 0; trap_num = 0;
  endtask

  task automatic run_instr(bit tr, logic [3:0] st, logic [3:0] tn);
    begin_instr(tr);
    @(negedge clk);
    end_instr(st, tn);
  endtask

  task automatic expect_vec(int exp, string req, int hold);
    int waited = 0;
    while (!vec_valid && waited < 40) begin
      @(negedge clk); waited++;
    end
    repeat (hold) @(negedge clk);
    checks++;
    if (!vec_valid || vec_num !== 8'(exp)) begin
      fails++;
      $display("FAIL %s vector: valid=%0b vec=%0d expected vec=%0d", req, vec_valid, vec_num, exp);
    end
    vec_accept = 1;
    if (exp >= 24 && exp < 32) irq_pend = 0;
    @(negedge clk);
    vec_accept = 0;
  endtask

  task automatic expect_idle(int n, string req);
    repeat (n) begin
      checks++;
      if (vec_valid !== 1'b0) begin
        fails++;
        $display("FAIL %s idle: valid=%0b vec=%0d expected valid=0", req, vec_valid, vec_num);
      end
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R9";
    expect_idle(3, "R9 reset state");

    tag = "R5";                                   // trace off: nothing
    run_instr(0, 4'd0, 4'd0);
    expect_idle(4, "R5 no trace when bit clear");
    run_instr(1, 4'd0, 4'd0);                      // trace on, normal
    expect_vec(9, "R5 trace after normal", 0);
    run_instr(1, 4'd12, 4'd0);                     // code 12 counts as normal
    expect_vec(9, "R5 trace after code 12", 0);
    expect_idle(3, "R5 drained");

    tag = "R4";                                   // fault encodings
    run_instr(0, 4'd6, 4'd0);  expect_vec(7,  "R4 overflow trap", 0);
    run_instr(0, 4'd7, 4'd0);  expect_vec(6,  "R4 bounds check", 0);
    run_instr(0, 4'd8, 4'd0);  expect_vec(5,  "R4 divide by zero", 0);
    run_instr(0, 4'd9, 4'd0);  expect_vec(14, "R4 format error", 0);
    run_instr(0, 4'd5, 4'd15); expect_vec(47, "R4 trap 15", 0);

    tag = "R6";                                   // skipped instructions
    run_instr(1, 4'd1, 4'd0); expect_vec(4,  "R6 illegal", 0);
    expect_idle(3, "R6 no trace after illegal");
    run_instr(1, 4'd2, 4'd0); expect_vec(8,  "R6 privileged", 0);
    run_instr(1, 4'd3, 4'd0); expect_vec(10, "R6 line 1010", 0);
    run_instr(1, 4'd4, 4'd0); expect_vec(11, "R6 line 1111", 0);
    expect_idle(3, "R6 no trace after line codes");

    tag = "R7";                                   // trap, trace, interrupt
    begin_instr(1);
    @(negedge clk);
    irq_pend = 1; irq_level = 3'd3;
    end_instr(4'd5, 4'd5);
    expect_vec(37, "R7 trap first", 0);
    expect_vec(9,  "R7 trace second", 0);
    expect_vec(27, "R7 interrupt last", 0);
    expect_idle(3, "R7 drained");

    tag = "R8";                                   // interrupt held back by instruction
    begin_instr(0);
    irq_pend = 1; irq_level = 3'd5;
    expect_idle(4, "R8 no interrupt mid-instruction");
    end_instr(4'd0, 4'd0);
    expect_vec(29, "R8 interrupt after end", 0);
    expect_idle(2, "R8 drained");

    tag = "R9";                                   // hold without accept
    run_instr(0, 4'd8, 4'd0);
    expect_vec(5, "R9 held vector", 6);

    tag = "R2";                                   // abort cancels trace
    begin_instr(1);
    repeat (2) @(negedge clk);
    pulse_abort(0, 0, 1);
    expect_vec(2, "R2 bus error", 0);
    expect_idle(4, "R2 no trace after abort");
    begin_instr(1);
    @(negedge clk);
    bus_err = 1; instr_done = 1; instr_status = 4'd5; trap_num = 4'd1;
    @(negedge clk);
    bus_err = 0; instr_done = 0; instr_status = 0; trap_num = 0;
    expect_vec(2, "R2 end strobe ignored with abort", 0);
    expect_idle(4, "R2 no fault or trace");

    tag = "R1";                                   // group ranking
    pulse_abort(0, 1, 1);
    expect_vec(3, "R1 address before bus", 0);
    expect_vec(2, "R1 bus after address", 0);
    pulse_abort(1, 1, 1);
    expect_vec(0, "R1 reset first", 0);
    expect_vec(3, "R1 address second", 0);
    expect_vec(2, "R1 bus third", 0);
    expect_idle(2, "R1 drained");

    tag = "R3";                                   // reset drops queue
    run_instr(1, 4'd5, 4'd2);
    while (!vec_valid) @(negedge clk);
    pulse_abort(1, 0, 0);
    expect_vec(34, "R3 shown vector kept", 0);
    expect_vec(0,  "R3 reset follows", 0);
    expect_idle(4, "R3 trace dropped");

    finish_run();
  end
endmodule